// File: doc/BRIEF.md
# Keyboard Status and Data Port

This block sits on a 16-bit core's load path and makes a keyboard look like two memory words. Keystrokes come in on a byte interface: a one-cycle valid strobe together with an 8-bit character code. The block holds the most recent character and a ready flag that shows whether software has picked that character up yet.

Software polls. A read of the status address returns right away and shows in its top bit whether a character is waiting. It never stalls. A read of the data address returns the held character and consumes it. The address decode raises a select whenever a read hits either register, and the read-data mux then puts the port's word on the bus instead of the memory word. Every other address reads memory unchanged. Writes to the two register addresses have no effect on the port.

Read data is combinational in the cycle of the access. Side effects, such as clearing the flag, take effect at the next rising clock edge.

Top module: `kbd_port`

## Requirements
- R1: After reset the ready flag is clear and the held character is 0x00, so a status read returns 0x0000 and a data read returns 0x0000.
- R2: A read at address 0xFE00 while a character is waiting returns 0x8000: bit 15 is set and all other bits are zero.
- R3: A read at address 0xFE00 while no character is waiting returns 0x0000.
- R4: A read at address 0xFE02 returns the held character in bits 7:0 with bits 15:8 zero. The character is still held after the flag has cleared.
- R5: A read at 0xFE02 clears the ready flag at the next clock edge, unless a character arrives in the same cycle.
- R6: A valid strobe sets the ready flag and loads the character at the next clock edge. If a character is already waiting, the new one overwrites it.
- R7: If a strobe and a data read fall in the same cycle, the read returns the old character. After the edge the flag is set and the new character is held.
- R8: A status read leaves the flag and the held character unchanged.
- R9: A read of any address other than 0xFE00 and 0xFE02, and any cycle with no read, drives the memory read word to the read-data output unchanged and keeps the select low.
- R10: A write to 0xFE00 or 0xFE02 changes neither the flag nor the held character.
- R11: The select output is high exactly in the cycles where a read hits 0xFE00 or 0xFE02.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_valid_i | input | 1 | One-cycle strobe for a new character |
| key_char_i | input | 8 | Character code that goes with the strobe |
| bus_addr_i | input | 16 | Word address of the bus access |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data, never stored by this block |
| mem_rdata_i | input | 16 | Read word from memory |
| bus_rdata_o | output | 16 | Read word after the port mux |
| kbd_sel_o | output | 1 | High when a read hits one of the two registers |

## Verification
Two events can land on the same clock edge: a keystroke arriving and software consuming the held character through a data read. The bench forces this case on purpose, with one or more characters already waiting, and also hits it again during a long mixed stretch of strobes and reads. In that case the read must return the old character, and the flag must stay set with the new character held. A behavioural model with two variables predicts every read word and select value each cycle. The bench compares the design against that model.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned CHAR_W    = 8;
  localparam int unsigned READY_BIT = 15;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 16'hFE00;
  localparam logic [ADDR_W-1:0] DATA_ADDR = 16'hFE02;

  typedef enum logic [0:0] {
    REG_STAT = 1'b0,
    REG_DATA = 1'b1
  } kbd_reg_e;
endpackage

// File: rtl/kbd_decode.sv
module kbd_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE02
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  output logic              hit_stat_o,
  output logic              hit_data_o,
  output logic              sel_o,
  output logic              data_rd_o
);
  localparam int unsigned N_REG = 2;
  localparam logic [ADDR_W-1:0] REG_ADDR [N_REG] = '{STAT_ADDR, DATA_ADDR};

  logic [N_REG-1:0] match;

  for (genvar g = 0; g < N_REG; g++) begin : g_match
    assign match[g] = (addr_i == REG_ADDR[g]);
  end

  assign hit_stat_o = rd_i & match[0];
  assign hit_data_o = rd_i & match[1];
  assign sel_o      = hit_stat_o | hit_data_o;
  assign data_rd_o  = hit_data_o;
endmodule

// File: rtl/kbd_hold.sv
module kbd_hold #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_valid_i,
  input  logic [CHAR_W-1:0] key_char_i,
  input  logic              consume_i,
  output logic              ready_o,
  output logic [CHAR_W-1:0] char_o
);
  logic              ready_q, ready_d;
  logic [CHAR_W-1:0] char_q, char_d;

  // arrival wins over consumption in the same cycle
  always_comb begin
    ready_d = ready_q;
    char_d  = char_q;
    if (key_valid_i) begin
      ready_d = 1'b1;
      char_d  = key_char_i;
    end else if (consume_i) begin
      ready_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      char_q  <= '0;
    end else begin
      ready_q <= ready_d;
      char_q  <= char_d;
    end
  end

  assign ready_o = ready_q;
  assign char_o  = char_q;
endmodule

// File: rtl/kbd_rmux.sv
module kbd_rmux #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned CHAR_W    = 8,
  parameter int unsigned READY_BIT = 15
) (
  input  logic              hit_stat_i,
  input  logic              hit_data_i,
  input  logic              ready_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = WORD_W - CHAR_W;

  logic [WORD_W-1:0] stat_word;
  logic [WORD_W-1:0] data_word;

  always_comb begin
    stat_word            = '0;
    stat_word[READY_BIT] = ready_i;
  end

  assign data_word = {{PAD_W{1'b0}}, char_i};

  always_comb begin
    if (hit_stat_i)      rdata_o = stat_word;
    else if (hit_data_i) rdata_o = data_word;
    else                 rdata_o = mem_rdata_i;
  end
endmodule

// File: rtl/kbd_port.sv
module kbd_port
  import kbd_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_valid_i,
  input  logic [CHAR_W-1:0] key_char_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              kbd_sel_o
);
  logic              hit_stat, hit_data, data_rd;
  logic              ready;
  logic [CHAR_W-1:0] held_char;

  // writes never reach the port registers
  logic unused_wr;
  assign unused_wr = bus_wr_i ^ (^bus_wdata_i);

  kbd_decode #(
    .ADDR_W   (ADDR_W),
    .STAT_ADDR(STAT_ADDR),
    .DATA_ADDR(DATA_ADDR)
  ) u_decode (
    .addr_i    (bus_addr_i),
    .rd_i      (bus_rd_i),
    .hit_stat_o(hit_stat),
    .hit_data_o(hit_data),
    .sel_o     (kbd_sel_o),
    .data_rd_o (data_rd)
  );

  kbd_hold #(
    .CHAR_W(CHAR_W)
  ) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_valid_i(key_valid_i),
    .key_char_i (key_char_i),
    .consume_i  (data_rd),
    .ready_o    (ready),
    .char_o     (held_char)
  );

  kbd_rmux #(
    .WORD_W   (WORD_W),
    .CHAR_W   (CHAR_W),
    .READY_BIT(READY_BIT)
  ) u_rmux (
    .hit_stat_i (hit_stat),
    .hit_data_i (hit_data),
    .ready_i    (ready),
    .char_i     (held_char),
    .mem_rdata_i(mem_rdata_i),
    .rdata_o    (bus_rdata_o)
  );
endmodule

// File: rtl/kbd_port_chk.sv
module kbd_port_chk
  import kbd_port_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              key_valid_i,
  input logic [CHAR_W-1:0] key_char_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_rd_i,
  input logic [WORD_W-1:0] mem_rdata_i,
  input logic [WORD_W-1:0] bus_rdata_o,
  input logic              kbd_sel_o,
  input logic              ready,
  input logic [CHAR_W-1:0] held_char
);
  logic is_stat, is_data;
  assign is_stat = bus_rd_i && (bus_addr_i == STAT_ADDR);
  assign is_data = bus_rd_i && (bus_addr_i == DATA_ADDR);

  a_r2_status_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_stat |-> bus_rdata_o == (ready ? 16'h8000 : 16'h0000));

  a_r4_data_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_data |-> bus_rdata_o == {8'h00, held_char});

  a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_data && !key_valid_i) |=> !ready);

  a_r6_arrival_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_i |=> (ready && held_char == $past(key_char_i)));

  a_r10_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!key_valid_i && !is_data) |=> ($stable(ready) && $stable(held_char)));

  a_r9_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_stat && !is_data) |-> (bus_rdata_o == mem_rdata_i && !kbd_sel_o));

  a_r11_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kbd_sel_o |-> (is_stat || is_data));
endmodule

bind kbd_port kbd_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .key_valid_i(key_valid_i),
  .key_char_i (key_char_i),
  .bus_addr_i (bus_addr_i),
  .bus_rd_i   (bus_rd_i),
  .mem_rdata_i(mem_rdata_i),
  .bus_rdata_o(bus_rdata_o),
  .kbd_sel_o  (kbd_sel_o),
  .ready      (ready),
  .held_char  (held_char)
);

// File: tb/tb_kbd_port.sv
`timescale 1ns/1ps
module tb_kbd_port;
  localparam real TCK = 8.0;
  localparam logic [15:0] A_STAT = 16'hFE00;
  localparam logic [15:0] A_DATA = 16'hFE02;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        key_valid_i = 1'b0;
  logic [7:0]  key_char_i = '0;
  logic [15:0] bus_addr_i = '0;
  logic        bus_rd_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] mem_rdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic        kbd_sel_o;

  int n_chk = 0;
  int n_fail = 0;
  bit m_ready = 1'b0;
  int m_char = 0;

  kbd_port dut (.*);

  always #(TCK/2) clk_i = ~clk_i;

  task automatic step(input bit kv, input logic [7:0] kc, input logic [15:0] a,
                      input bit rd, input bit wr, input logic [15:0] mem,
                      input string tag);
    logic [15:0] exp_d;
    bit exp_s;
    @(negedge clk_i);
    key_valid_i = kv; key_char_i = kc; bus_addr_i = a;
    bus_rd_i = rd; bus_wr_i = wr; bus_wdata_i = 16'hA5A5; mem_rdata_i = mem;
    #1;
    if (rd && a == A_STAT) begin
      exp_s = 1; exp_d = m_ready ? 16'h8000 : 16'h0000;
    end else if (rd && a == A_DATA) begin
      exp_s = 1; exp_d = 16'(m_char);
    end else begin
      exp_s = 0; exp_d = mem;
    end
    n_chk++;
    if (bus_rdata_o !== exp_d || kbd_sel_o !== exp_s) begin
      n_fail++;
      $display("FAIL %s: rdata=%h sel=%b expected rdata=%h sel=%b",
               tag, bus_rdata_o, kbd_sel_o, exp_d, exp_s);
    end
    @(posedge clk_i);
    if (kv) begin
      m_ready = 1'b1; m_char = int'(kc);
    end else if (rd && a == A_DATA) begin
      m_ready = 1'b0;
    end
  endtask

  initial begin
    #(TCK * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    step(0, 8'h00, A_STAT, 1, 0, 16'h1111, "R1 status after reset");
    step(0, 8'h00, A_DATA, 1, 0, 16'h1111, "R1 data after reset");
    step(0, 8'h00, A_STAT, 1, 0, 16'h2222, "R3 idle status");
    step(1, 8'h41, 16'h3000, 1, 0, 16'hE002, "R9 read during arrival");
    step(0, 8'h00, A_STAT, 1, 0, 16'h0, "R2 status ready");
    step(0, 8'h00, A_STAT, 1, 0, 16'h0, "R8 status again keeps flag");
    step(0, 8'h00, A_DATA, 1, 0, 16'h0, "R4 data read");
    step(0, 8'h00, A_STAT, 1, 0, 16'h0, "R5 flag cleared");
    step(0, 8'h00, A_DATA, 1, 0, 16'h0, "R4 char kept after clear");
    step(1, 8'h62, 16'h0, 0, 0, 16'h0, "R11 no read no select");
    step(1, 8'hF7, 16'h0, 0, 0, 16'h0, "R6 overwrite strobe");
    step(0, 8'h00, A_DATA, 1, 0, 16'h0, "R6 overwritten char");
    step(1, 8'h33, 16'h0, 0, 0, 16'h0, "R7 setup");
    step(1, 8'h5A, A_DATA, 1, 0, 16'h0, "R7 old char on collision");
    step(0, 8'h00, A_STAT, 1, 0, 16'h0, "R7 flag still set");
    step(0, 8'h00, A_DATA, 1, 0, 16'h0, "R7 new char held");
    step(1, 8'h7E, 16'h0, 0, 0, 16'h0, "R10 setup");
    step(0, 8'h00, A_DATA, 0, 1, 16'hBEEF, "R10 write data addr");
    step(0, 8'h00, A_STAT, 0, 1, 16'hCAFE, "R10 write status addr");
    step(0, 8'h00, A_STAT, 1, 0, 16'h0, "R10 flag kept");
    step(0, 8'h00, A_DATA, 1, 0, 16'h0, "R10 char kept");
    step(0, 8'h00, A_STAT, 0, 0, 16'h5151, "R9 no read on status addr");
    step(0, 8'h00, 16'hFE01, 1, 0, 16'h6161, "R9 neighbour address");
    step(0, 8'h00, 16'hFE03, 1, 0, 16'h7171, "R9 neighbour above");
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      int sel;
      sel = int'($urandom_range(0, 3));
      a = (sel == 0) ? A_STAT : (sel == 1) ? A_DATA : 16'($urandom);
      step(bit'($urandom_range(0, 3) == 0), 8'($urandom), a,
           bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), 16'($urandom),
           sel == 0 ? "R2 R3 mixed status" : sel == 1 ? "R4 R5 R7 mixed data" : "R9 R11 mixed other");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule